// File: doc/BRIEF.md
# Header-Credit Threshold Throttle

This block watches how many header credits a PCIe-style link partner has granted for two traffic classes: posted requests (writes) and non-posted requests (reads). It keeps one up/down counter per class. The counter is loaded with the partner's initial grant when the link comes up. It then moves with consume pulses from the transmit side and return pulses from the credit-update path. For each class, a registered almost-full flag tells the transaction layer to hold back new requests of that class while the credits left are below a software-programmed floor.

Each floor is an 8-bit register that software can write and read back at any time. A floor larger than the partner's initial grant would keep the flag asserted forever, and that class would never issue again. To prevent this, the block lowers each floor to the initial grant at the moment the link comes up, whenever the grant is nonzero and smaller than the floor. Readback returns the lowered value.

A grant of zero means the partner advertises unlimited credit for that class. That class is then never throttled and is never clamped. Pulses that would take a counter below zero or above its maximum are dropped, and each such event sets a per-class sticky error flag.

Top module: `hdr_credit_throttle`

## Requirements
- R1: After reset, both almost-full outputs are 1, both error flags are 0, and both floor readbacks equal the parameter MIN_RESET (default 16).
- R2: While link_up is 0, both almost-full outputs are 1 and both counters are held at zero. Consume and return pulses have no effect and set no error.
- R3: In the first cycle in which link_up is 1 after being 0, each counter loads its class's initial grant. Pulses in that cycle are ignored.
- R4: With the link up, a consume pulse lowers the class counter by one and a return pulse raises it by one. Both pulses in the same cycle leave it unchanged.
- R5: An almost-full output is 1 exactly when its class counter is less than its class floor. The two classes are independent.
- R6: On link-up, if a class's initial grant is nonzero and smaller than its floor, the floor is overwritten with the grant, and readback shows the new value. Otherwise the floor is kept.
- R7: A floor write (write enable high for one cycle, value on floor_wdata) takes effect in the next cycle, with no further clamp after link-up. A write in the same cycle as link-up takes priority over the clamp.
- R8: An initial grant of 0 makes that class unlimited until the link next goes down. Its almost-full output stays 0, its floor is not clamped, and its pulses are ignored without error.
- R9: A consume pulse at count 0, or a return pulse at count 255, is dropped. The counter keeps its value, and the class's sticky error flag becomes 1 and stays 1 until reset.
- R10: The almost-full outputs are registered. They reflect a counter or floor change one clock after that change is stored, which is two clocks after the causing input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_up | input | 1 | Link is up; its rising edge loads the grants |
| post_init_cr | input | 8 | Partner's initial posted-header grant |
| np_init_cr | input | 8 | Partner's initial non-posted-header grant |
| post_use | input | 1 | One posted-header credit consumed |
| post_ret | input | 1 | One posted-header credit returned |
| np_use | input | 1 | One non-posted-header credit consumed |
| np_ret | input | 1 | One non-posted-header credit returned |
| post_floor_we | input | 1 | Write strobe for the posted floor |
| np_floor_we | input | 1 | Write strobe for the non-posted floor |
| floor_wdata | input | 8 | Write data for either floor |
| post_floor_rd | output | 8 | Current posted floor |
| np_floor_rd | output | 8 | Current non-posted floor |
| post_af | output | 1 | Posted almost-full toward the transaction layer |
| np_af | output | 1 | Non-posted almost-full toward the transaction layer |
| post_err | output | 1 | Sticky posted underflow/overflow flag |
| np_err | output | 1 | Sticky non-posted underflow/overflow flag |

## Verification
The assertions check these on every cycle: the link-down hold of counters and flags, the grant load on link-up, the no-change rule for paired pulses, holding at zero with the sticky error, the clamp value and the rule that a floor never rises without a write, and the quiet flag of an unlimited class. The directed scenarios show what only end-to-end sequences reveal. They cover the exact cycle in which each flag flips, the independence of the two classes, write-versus-clamp priority, and the absence of a wrap at 0 and at 255, which shows up only in the flag after a later opposite pulse.

// File: rtl/cr_pkg.sv
package cr_pkg;
  localparam int CR_NCLS = 2;
  localparam int CR_POST = 0;
  localparam int CR_NP   = 1;

  typedef struct packed {
    logic use_p;
    logic ret_p;
  } cr_pulse_t;
endpackage

// File: rtl/cr_counter.sv
module cr_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         link_up,
  input  logic         link_rise,
  input  logic [W-1:0] init_cr,
  input  logic         use_p,
  input  logic         ret_p,
  output logic [W-1:0] cnt_o,
  output logic         inf_o,
  output logic         err_o
);
  localparam logic [W-1:0] CMAX = {W{1'b1}};
  localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] cnt_q, cnt_d;
  logic         inf_q, inf_d;
  logic         err_q, err_d;
  logic         step, en;

  assign step = link_up && !link_rise && !inf_q && (use_p ^ ret_p);
  assign en   = !link_up || link_rise || step;

  always_comb begin
    cnt_d = cnt_q;
    inf_d = inf_q;
    err_d = err_q;
    if (!link_up) begin
      cnt_d = '0;
      inf_d = 1'b0;
    end else if (link_rise) begin
      cnt_d = init_cr;
      inf_d = (init_cr == '0);
    end else if (step) begin
      if (use_p) begin
        if (cnt_q == '0) err_d = 1'b1;
        else             cnt_d = cnt_q - ONE;
      end else begin
        if (cnt_q == CMAX) err_d = 1'b1;
        else               cnt_d = cnt_q + ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      inf_q <= 1'b0;
      err_q <= 1'b0;
    end else if (en) begin
      cnt_q <= cnt_d;
      inf_q <= inf_d;
      err_q <= err_d;
    end
  end

  assign cnt_o = cnt_q;
  assign inf_o = inf_q;
  assign err_o = err_q;

  p_down_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !link_up |=> (cnt_q == '0));
  p_load_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (link_up && link_rise) |=> (cnt_q == $past(init_cr)));
  p_pair_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (link_up && !link_rise && use_p && ret_p) |=> $stable(cnt_q));
  p_no_underflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (link_up && !link_rise && !inf_q && use_p && !ret_p && cnt_q == '0)
      |=> (cnt_q == '0 && err_q));
  p_sticky_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);
endmodule

// File: rtl/cr_floor_reg.sv
module cr_floor_reg #(
  parameter int              W         = 8,
  parameter logic [W-1:0]    MIN_RESET = 8'd16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         link_rise,
  input  logic [W-1:0] init_cr,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] floor_o
);
  logic [W-1:0] floor_q, floor_d;
  logic         clamp, en;

  assign clamp = link_rise && (init_cr != '0) && (init_cr < floor_q);
  assign en    = we || clamp;

  always_comb begin
    floor_d = floor_q;
    if (we)         floor_d = wdata;
    else if (clamp) floor_d = init_cr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  floor_q <= MIN_RESET;
    else if (en) floor_q <= floor_d;
  end

  assign floor_o = floor_q;

  p_clamp_value_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (link_rise && !we && init_cr != '0 && init_cr < floor_q)
      |=> (floor_q == $past(init_cr)));
  p_never_raised_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> (floor_q <= $past(floor_q)));
  p_write_lands_r7: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (floor_q == $past(wdata)));
endmodule

// File: rtl/cr_class.sv
module cr_class #(
  parameter int           W         = 8,
  parameter logic [W-1:0] MIN_RESET = 8'd16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         link_up,
  input  logic         link_rise,
  input  logic [W-1:0] init_cr,
  input  logic         use_p,
  input  logic         ret_p,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] floor_o,
  output logic         af_o,
  output logic         err_o
);
  logic [W-1:0] cnt;
  logic         inf;
  logic         af_q, af_d;

  cr_counter #(.W(W)) i_cnt (
    .clk(clk), .rst_n(rst_n), .link_up(link_up), .link_rise(link_rise),
    .init_cr(init_cr), .use_p(use_p), .ret_p(ret_p),
    .cnt_o(cnt), .inf_o(inf), .err_o(err_o)
  );

  cr_floor_reg #(.W(W), .MIN_RESET(MIN_RESET)) i_floor (
    .clk(clk), .rst_n(rst_n), .link_rise(link_rise), .init_cr(init_cr),
    .we(we), .wdata(wdata), .floor_o(floor_o)
  );

  always_comb begin
    af_d = 1'b1;
    if (link_up) af_d = !inf && (cnt < floor_o);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) af_q <= 1'b1;
    else        af_q <= af_d;
  end

  assign af_o = af_q;

  p_down_af_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !link_up |=> af_q);
  p_unlimited_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (link_up && inf) |=> !af_q);
  p_low_count_af_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (link_up && !inf && cnt < floor_o) |=> af_q);
endmodule

// File: rtl/hdr_credit_throttle.sv
module hdr_credit_throttle
  import cr_pkg::*;
#(
  parameter int           CW        = 8,
  parameter logic [CW-1:0] MIN_RESET = 8'd16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          link_up,
  input  logic [CW-1:0] post_init_cr,
  input  logic [CW-1:0] np_init_cr,
  input  logic          post_use,
  input  logic          post_ret,
  input  logic          np_use,
  input  logic          np_ret,
  input  logic          post_floor_we,
  input  logic          np_floor_we,
  input  logic [CW-1:0] floor_wdata,
  output logic [CW-1:0] post_floor_rd,
  output logic [CW-1:0] np_floor_rd,
  output logic          post_af,
  output logic          np_af,
  output logic          post_err,
  output logic          np_err
);
  logic link_q, link_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) link_q <= 1'b0;
    else        link_q <= link_up;
  end

  assign link_rise = link_up && !link_q;

  cr_pulse_t         pls   [CR_NCLS];
  logic [CW-1:0]     init  [CR_NCLS];
  logic              we    [CR_NCLS];
  logic [CW-1:0]     flr   [CR_NCLS];
  logic              af    [CR_NCLS];
  logic              err   [CR_NCLS];

  assign pls[CR_POST]  = '{use_p: post_use, ret_p: post_ret};
  assign pls[CR_NP]    = '{use_p: np_use,   ret_p: np_ret};
  assign init[CR_POST] = post_init_cr;
  assign init[CR_NP]   = np_init_cr;
  assign we[CR_POST]   = post_floor_we;
  assign we[CR_NP]     = np_floor_we;

  for (genvar c = 0; c < CR_NCLS; c++) begin : g_cls
    cr_class #(.W(CW), .MIN_RESET(MIN_RESET)) i_cls (
      .clk(clk), .rst_n(rst_n), .link_up(link_up), .link_rise(link_rise),
      .init_cr(init[c]), .use_p(pls[c].use_p), .ret_p(pls[c].ret_p),
      .we(we[c]), .wdata(floor_wdata),
      .floor_o(flr[c]), .af_o(af[c]), .err_o(err[c])
    );
  end

  assign post_floor_rd = flr[CR_POST];
  assign np_floor_rd   = flr[CR_NP];
  assign post_af       = af[CR_POST];
  assign np_af         = af[CR_NP];
  assign post_err      = err[CR_POST];
  assign np_err        = err[CR_NP];

  p_rise_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
    link_rise |=> !link_rise);
endmodule

// File: tb/test_hdr_credit_throttle.sv
module test_hdr_credit_throttle;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       link_up;
  logic [7:0] post_init_cr, np_init_cr, floor_wdata;
  logic       post_use, post_ret, np_use, np_ret, post_floor_we, np_floor_we;
  logic [7:0] post_floor_rd, np_floor_rd;
  logic       post_af, np_af, post_err, np_err;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hdr_credit_throttle i_hdr_credit_throttle (
    .clk(clk), .rst_n(rst_n), .link_up(link_up),
    .post_init_cr(post_init_cr), .np_init_cr(np_init_cr),
    .post_use(post_use), .post_ret(post_ret), .np_use(np_use), .np_ret(np_ret),
    .post_floor_we(post_floor_we), .np_floor_we(np_floor_we),
    .floor_wdata(floor_wdata),
    .post_floor_rd(post_floor_rd), .np_floor_rd(np_floor_rd),
    .post_af(post_af), .np_af(np_af), .post_err(post_err), .np_err(np_err)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // One pulse cycle, then sample after the flag register has followed.
  task automatic pulse(input logic pu, input logic pr, input logic nu, input logic nr);
    post_use = pu; post_ret = pr; np_use = nu; np_ret = nr;
    @(negedge clk);
    post_use = 0; post_ret = 0; np_use = 0; np_ret = 0;
    @(negedge clk);
  endtask

  task automatic wr_floor(input logic p, input logic n, input logic [7:0] v);
    post_floor_we = p; np_floor_we = n; floor_wdata = v;
    @(negedge clk);
    post_floor_we = 0; np_floor_we = 0;
  endtask

  task automatic go_up(input logic [7:0] ip, input logic [7:0] in_);
    post_init_cr = ip; np_init_cr = in_; link_up = 1;
    idle(2);
  endtask

  task automatic go_down;
    link_up = 0;
    idle(1);
  endtask

  task automatic t_reset;
    chk("R1", "post_af", post_af, 1);
    chk("R1", "np_af", np_af, 1);
    chk("R1", "post_err", post_err, 0);
    chk("R1", "np_err", np_err, 0);
    chk("R1", "post_floor", post_floor_rd, 16);
    chk("R1", "np_floor", np_floor_rd, 16);
  endtask

  task automatic t_clamp_and_write;
    wr_floor(1, 0, 8'd200);
    wr_floor(0, 1, 8'd10);
    go_up(8'd50, 8'd30);
    chk("R6", "post floor clamped", post_floor_rd, 50);
    chk("R6", "np floor kept", np_floor_rd, 10);
    chk("R3", "post_af after load", post_af, 0);
    chk("R3", "np_af after load", np_af, 0);
    // R7 and R10: raise the floor above the count after link-up
    wr_floor(1, 0, 8'd60);
    chk("R7", "post floor no reclamp", post_floor_rd, 60);
    chk("R10", "post_af one cycle after floor write", post_af, 0);
    idle(1);
    chk("R10", "post_af two cycles after floor write", post_af, 1);
    go_down();
  endtask

  task automatic t_write_vs_clamp;
    post_init_cr = 8'd20; np_init_cr = 8'd40; link_up = 1;
    post_floor_we = 1; floor_wdata = 8'd100;
    @(negedge clk);
    post_floor_we = 0;
    @(negedge clk);
    chk("R7", "write wins over clamp", post_floor_rd, 100);
    chk("R5", "post_af count below floor", post_af, 1);
    go_down();
  endtask

  task automatic t_count;
    wr_floor(1, 0, 8'd3);
    wr_floor(0, 1, 8'd8);
    go_up(8'd5, 8'd8);
    chk("R5", "np_af count equals floor", np_af, 0);
    pulse(0, 0, 1, 0);
    chk("R5", "np_af after consume", np_af, 1);
    chk("R5", "post_af independent", post_af, 0);
    pulse(0, 0, 0, 1);
    chk("R4", "np_af after return", np_af, 0);
    pulse(1, 0, 0, 0);
    pulse(1, 0, 0, 0);
    chk("R4", "post_af at count 3", post_af, 0);
    pulse(1, 0, 0, 0);
    chk("R4", "post_af at count 2", post_af, 1);
    pulse(1, 1, 0, 0);
    chk("R4", "paired pulses no change", post_af, 1);
    pulse(0, 1, 0, 0);
    chk("R4", "post_af back to count 3", post_af, 0);
    go_down();
  endtask

  task automatic t_link_down;
    go_up(8'd9, 8'd9);
    link_up = 0;
    @(negedge clk);
    chk("R2", "post_af on drop", post_af, 1);
    chk("R2", "np_af on drop", np_af, 1);
    pulse(0, 1, 0, 1);
    pulse(1, 0, 1, 0);
    chk("R2", "post_af held while down", post_af, 1);
    chk("R2", "no error while down", post_err, 0);
  endtask

  task automatic t_unlimited;
    wr_floor(1, 0, 8'd5);
    go_up(8'd0, 8'd30);
    chk("R8", "post floor not clamped", post_floor_rd, 5);
    chk("R8", "post_af unlimited", post_af, 0);
    pulse(1, 0, 0, 0);
    pulse(1, 0, 0, 0);
    chk("R8", "post_af after consumes", post_af, 0);
    chk("R8", "no error on unlimited", post_err, 0);
    go_down();
  endtask

  task automatic t_underflow;
    wr_floor(0, 1, 8'd1);
    go_up(8'd30, 8'd1);
    chk("R9", "np_af at count 1", np_af, 0);
    pulse(0, 0, 1, 0);
    chk("R9", "np_af at count 0", np_af, 1);
    chk("R9", "np_err before underflow", np_err, 0);
    pulse(0, 0, 1, 0);
    chk("R9", "np_err after underflow", np_err, 1);
    pulse(0, 0, 0, 1);
    chk("R9", "count held at 0 (return gives 1)", np_af, 0);
    chk("R9", "np_err sticky", np_err, 1);
    chk("R9", "post_err untouched", post_err, 0);
    go_down();
  endtask

  task automatic t_overflow;
    wr_floor(1, 0, 8'd255);
    go_up(8'd255, 8'd30);
    chk("R9", "post_af at 255", post_af, 0);
    pulse(0, 1, 0, 0);
    chk("R9", "post_err after overflow", post_err, 1);
    chk("R9", "no wrap to 0", post_af, 0);
    pulse(1, 0, 0, 0);
    chk("R9", "post_af at 254", post_af, 1);
    go_down();
    chk("R9", "post_err sticky across link down", post_err, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    n_err++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    rst_n = 0; link_up = 0; post_init_cr = 0; np_init_cr = 0;
    post_use = 0; post_ret = 0; np_use = 0; np_ret = 0;
    post_floor_we = 0; np_floor_we = 0; floor_wdata = 0;
    idle(3);
    rst_n = 1;
    idle(2);
    t_reset();
    t_clamp_and_write();
    t_write_vs_clamp();
    t_count();
    t_link_down();
    t_unlimited();
    t_underflow();
    t_overflow();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule